// File: doc/BRIEF.md
# Four-Digit Hex Display Scanner

This block drives a four-digit, common-cathode, seven-segment display from a 16-bit value. Only one digit is lit at any moment. An external periodic timer supplies a single-cycle `tick` strobe. Each tick moves the display on to the next digit in a fixed rotation, so the four digits appear steady to the eye.

On a tick the block turns every digit off for one clock cycle. During that cycle it works out the next digit from the select pattern that was active, and it captures the nibble of the value that belongs to that digit. On the following cycle it lights that digit and drives the hex glyph of the captured nibble. After reset the display stays dark until the first tick arrives.

Top module: `hex_scan4`

## Requirements
- R1: While reset is asserted, and after it is released until the first tick, `dig_sel_n` is 4'b1111 and `seg` is 7'h00.
- R2: On successive ticks, `dig_sel_n` follows the rotation 1110 → 1101 → 1011 → 0111 → 1110.
- R3: A tick taken while `dig_sel_n` is any pattern other than 1110, 1101 or 1011 leads to the pattern 1110. This covers the all-off pattern and 0111.
- R4: In the cycle after a tick edge, `dig_sel_n` is 4'b1111 and `seg` is 7'h00. One cycle later the new digit and its glyph appear together.
- R5: The nibble shown depends on the pattern: 1110 shows value[15:12], 1101 shows value[11:8], 1011 shows value[7:4] and 0111 shows value[3:0].
- R6: `seg` is active high, with segment a in bit 0 through segment g in bit 6. The glyphs for nibbles 0 to F are 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F, 77, 7C, 39, 5E, 79, 71.
- R7: `value` is sampled only at the tick edge. A change to `value` after that edge does not alter the digit shown until the next tick.
- R8: At most one bit of `dig_sel_n` is low at any time. With no tick, `dig_sel_n` and `seg` hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle strobe that advances to the next digit |
| value | input | 16 | Value to display as four hex digits |
| dig_sel_n | output | 4 | Active-low digit enables |
| seg | output | 7 | Active-high segment bus, segment a in bit 0 |

## Verification
A corrupted select register shows at the port on the next tick. If two digits are enabled at once, both appear on `dig_sel_n` at once. An illegal code is replaced by 1110 one tick later, so the rotation restarts from the top digit and skips the expected digit. A wrong captured nibble or a wrong glyph appears on `seg` in the same cycle the digit lights, which is two edges after the tick. Every one of these faults can therefore be seen within one tick period.

// File: rtl/hex_scan4.sv
module hex_scan4 (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic [15:0] value,
  output logic [3:0]  dig_sel_n,
  output logic [6:0]  seg
);

  logic [3:0] nxt_c, nxt_q, nib_c, nib_q;
  logic       pend_q;

  function automatic logic [6:0] glyph(input logic [3:0] n);
    case (n)
      4'h0: glyph = 7'h3F;
      4'h1: glyph = 7'h06;
      4'h2: glyph = 7'h5B;
      4'h3: glyph = 7'h4F;
      4'h4: glyph = 7'h66;
      4'h5: glyph = 7'h6D;
      4'h6: glyph = 7'h7D;
      4'h7: glyph = 7'h07;
      4'h8: glyph = 7'h7F;
      4'h9: glyph = 7'h6F;
      4'hA: glyph = 7'h77;
      4'hB: glyph = 7'h7C;
      4'hC: glyph = 7'h39;
      4'hD: glyph = 7'h5E;
      4'hE: glyph = 7'h79;
      default: glyph = 7'h71;
    endcase
  endfunction

  always_comb begin
    case (dig_sel_n)
      4'b1110: nxt_c = 4'b1101;
      4'b1101: nxt_c = 4'b1011;
      4'b1011: nxt_c = 4'b0111;
      default: nxt_c = 4'b1110;
    endcase
  end

  always_comb begin
    case (nxt_c)
      4'b1110: nib_c = value[15:12];
      4'b1101: nib_c = value[11:8];
      4'b1011: nib_c = value[7:4];
      default: nib_c = value[3:0];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dig_sel_n <= 4'b1111;
      seg       <= 7'h00;
      nxt_q     <= 4'b1111;
      nib_q     <= 4'h0;
      pend_q    <= 1'b0;
    end else if (tick) begin
      dig_sel_n <= 4'b1111;
      seg       <= 7'h00;
      nxt_q     <= nxt_c;
      nib_q     <= nib_c;
      pend_q    <= 1'b1;
    end else if (pend_q) begin
      dig_sel_n <= nxt_q;
      seg       <= glyph(nib_q);
      pend_q    <= 1'b0;
    end
  end

  // R8
  one_digit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~dig_sel_n) <= 1);

  // R4
  blank_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (dig_sel_n == 4'b1111 && seg == 7'h00));

  // R3
  restart_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && dig_sel_n == 4'b1111) ##1 !tick |=> dig_sel_n == 4'b1110);

  // R2
  lit_after_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick ##1 !tick |=> dig_sel_n != 4'b1111);

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !pend_q) |=> ($stable(dig_sel_n) && $stable(seg)));

endmodule

// File: tb/hex_scan4_tb_top.sv
module hex_scan4_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic [15:0] value = 16'h0;
  logic [3:0] dig_sel_n;
  logic [6:0] seg;
  int checks = 0, fails = 0;
  logic [3:0] exp_sel;

  always #2 clk = ~clk;

  hex_scan4 dut_i (.clk(clk), .rst_n(rst_n), .tick(tick), .value(value),
                   .dig_sel_n(dig_sel_n), .seg(seg));

  function automatic logic [6:0] exp_glyph(input logic [3:0] n);
    logic [6:0] t [16] = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66, 7'h6D, 7'h7D, 7'h07,
                           7'h7F, 7'h6F, 7'h77, 7'h7C, 7'h39, 7'h5E, 7'h79, 7'h71};
    return t[n];
  endfunction

  function automatic logic [3:0] exp_next(input logic [3:0] s);
    if (s == 4'b1110) return 4'b1101;
    if (s == 4'b1101) return 4'b1011;
    if (s == 4'b1011) return 4'b0111;
    return 4'b1110;
  endfunction

  function automatic logic [3:0] exp_nib(input logic [3:0] s, input logic [15:0] v);
    int pos;
    pos = (s == 4'b1110) ? 3 : (s == 4'b1101) ? 2 : (s == 4'b1011) ? 1 : 0;
    return v[pos*4 +: 4];
  endfunction

  task automatic check(input string req, input logic [10:0] act, input logic [10:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got sel/seg %h, expected %h", req, act, exp);
    end
  endtask

  task automatic do_tick(input logic [15:0] v, input string req);
    @(negedge clk); tick = 1'b1; value = v;
    @(negedge clk); tick = 1'b0;
    check("R4 blank", {dig_sel_n, seg}, {4'b1111, 7'h00});
    @(negedge clk);
    exp_sel = exp_next(exp_sel);
    check(req, {dig_sel_n, seg}, {exp_sel, exp_glyph(exp_nib(exp_sel, v))});
  endtask

  initial begin
    #150000;
    fails++; checks++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    exp_sel = 4'b1111;
    repeat (3) @(negedge clk);
    check("R1 in reset", {dig_sel_n, seg}, {4'b1111, 7'h00});
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R1 idle before first tick", {dig_sel_n, seg}, {4'b1111, 7'h00});

    // R2 R5 R6: every nibble value in every digit position
    for (int v = 0; v < 16; v++) begin
      for (int k = 0; k < 4; k++) begin
        do_tick({v[3:0], v[3:0] + 4'd1, v[3:0] + 4'd2, v[3:0] + 4'd3}, "R2/R5/R6 sweep");
      end
    end

    // R5 pseudo-random values
    lfsr = 16'hACE1;
    for (int i = 0; i < 40; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      do_tick(lfsr, "R5 random value");
    end

    // R7: value changes during blank and while lit
    @(negedge clk); tick = 1'b1; value = 16'h1234;
    @(negedge clk); tick = 1'b0; value = 16'hFFFF;
    @(negedge clk);
    exp_sel = exp_next(exp_sel);
    check("R7 value sampled at tick", {dig_sel_n, seg},
          {exp_sel, exp_glyph(exp_nib(exp_sel, 16'h1234))});
    repeat (10) @(negedge clk);
    check("R8 hold without tick", {dig_sel_n, seg},
          {exp_sel, exp_glyph(exp_nib(exp_sel, 16'h1234))});

    // R3: back-to-back ticks see all-off pattern and restart at 1110
    @(negedge clk); tick = 1'b1; value = 16'h9ABC;
    @(negedge clk);
    @(negedge clk); tick = 1'b0;
    @(negedge clk);
    exp_sel = 4'b1110;
    check("R3 restart from all-off", {dig_sel_n, seg}, {4'b1110, exp_glyph(4'h9)});

    // R3: 0111 advances to 1110
    do_tick(16'h5000, "R3 after 1110");
    do_tick(16'h0500, "R3 after 1101");
    do_tick(16'h0050, "R3 after 1011");
    do_tick(16'h7000, "R3 0111 wraps to 1110");
    check("R3 wrap pattern", {7'h0, dig_sel_n}, {7'h0, 4'b1110});

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule